// File: doc/BRIEF.md
# Dual-Mode UART Oversampling Tick Generator

This block turns the system clock into the enable tick that paces a UART's 16x oversampled transmit and receive logic. The tick therefore runs at sixteen times the bit rate. A single 16-bit rate value sets the tick rate, and a run-time select chooses how that value is read.

In counter mode the value is an integer period. The tick fires once every N clocks, where N is the clock frequency divided by sixteen times the bit rate. This mode suits low bit rates, below about 19.2 kbit/s. In accumulator mode the value is a phase increment. It is added every clock to a 16-bit phase register, and each carry out of that addition makes a tick. The value is then the bit rate times 16 times 2^16, divided by the clock frequency. This gives fine fractional control and is the better choice at high bit rates.

A run enable gates the whole generator. Holding it low parks the generator in its low-power state with all its state at zero. Any change of mode or rate value while running costs one clear cycle, after which the generator restarts from zero.

Top module: `dual_rate_tick`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `tickOut` is 0.
- R2: While `runEn` is 0, `tickOut` stays 0. Both the counter and the phase register are held at zero, so on resuming with the same settings the first tick comes a full interval after `runEn` rises.
- R3: With `accSel` = 0 (counter mode) and `rateVal` = N ≥ 2, the first tick comes on the N-th enabled clock. Later ticks are exactly N clocks apart, giving floor(M/N) ticks over M enabled clocks.
- R4: In counter mode a `rateVal` of 0 or 1 gives a tick on every enabled clock.
- R5: With `accSel` = 1 (accumulator mode) and `rateVal` = V > 0, the phase register starts at zero. Over M enabled clocks it yields floor(M·V/65536) ticks, and the first tick comes on clock ceil(65536/V).
- R6: Each tick is a single-cycle pulse whenever counter mode has N ≥ 2 or accumulator mode has V < 32768.
- R7: A change of `accSel` while running gives one clock with no tick, during which all state is cleared. Counting restarts from zero on the following clock.
- R8: A change of `rateVal` while running clears all state and restarts counting in the same way as R7.
- R9: In accumulator mode a `rateVal` of 0 never produces a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Generator enable; 0 stops and clears it |
| accSel | input | 1 | 0 = integer counter mode, 1 = phase accumulator mode |
| rateVal | input | RATE_W (16) | Period (counter mode) or phase increment (accumulator mode) |
| tickOut | output | 1 | Single-cycle oversampling enable tick |

## Verification
The hardest case to reach from the ports is a restart that leaves a partly advanced counter or phase register behind. That case matters only when the old state would have produced an early tick. To reach it, the stimulus first runs the generator part way, with a phase of 0xC000 or a counter at 3 of 5. It then flips the mode out and back, or changes the rate, at a chosen cycle. The bench then checks the exact clock of the first tick, which differs by one or more cycles if any stale state survives. Random rounds over both modes compare the tick count and the first-tick position against closed-form expectations.

// File: rtl/dual_rate_tick_pkg.sv
package dual_rate_tick_pkg;

  // Strobes from the control to the datapath; at most one is active per cycle.
  typedef struct packed {
    logic clr;      // zero all state, suppress tick
    logic stepDiv;  // advance the integer counter
    logic stepAcc;  // advance the phase accumulator
  } tickStrobes_t;

endpackage

// File: rtl/dual_rate_tick_ctrl.sv
module dual_rate_tick_ctrl
  import dual_rate_tick_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              accSel,
  input  logic [RATE_W-1:0] rateVal,
  output tickStrobes_t      strobes
);

  logic              modeQ;
  logic [RATE_W-1:0] rateQ;
  logic              cfgChange;

  // Remember the configuration seen on the previous clock.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= 1'b0;
      rateQ <= '0;
    end else begin
      modeQ <= accSel;
      rateQ <= rateVal;
    end
  end

  always_comb begin
    cfgChange       = (accSel != modeQ) || (rateVal != rateQ);
    strobes.clr     = !runEn || cfgChange;
    strobes.stepDiv = runEn && !cfgChange && !accSel;
    strobes.stepAcc = runEn && !cfgChange && accSel;
  end

  // R7: the datapath never sees two actions in one cycle
  p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clr, strobes.stepDiv, strobes.stepAcc}));

  // R2: a stopped generator is never stepped
  p_idle_no_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !(strobes.stepDiv || strobes.stepAcc));

endmodule

// File: rtl/dual_rate_tick_dp.sv
module dual_rate_tick_dp
  import dual_rate_tick_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tickStrobes_t      strobes,
  input  logic [RATE_W-1:0] rateVal,
  output logic              tickQ
);

  localparam logic [RATE_W-1:0] ONE  = RATE_W'(1);
  localparam logic [RATE_W-1:0] HALF = RATE_W'(1) << (RATE_W - 1);

  logic [RATE_W-1:0] cntQ;
  logic [RATE_W-1:0] phaseQ;
  logic [RATE_W:0]   phaseSum;
  logic              cntWrap;

  always_comb begin
    phaseSum = {1'b0, phaseQ} + {1'b0, rateVal};
    cntWrap  = (rateVal <= ONE) || (cntQ == rateVal - ONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clr) begin
      cntQ   <= '0;
      phaseQ <= '0;
      tickQ  <= 1'b0;
    end else if (strobes.stepDiv) begin
      if (cntWrap) begin
        cntQ  <= '0;
        tickQ <= 1'b1;
      end else begin
        cntQ  <= cntQ + ONE;
        tickQ <= 1'b0;
      end
    end else if (strobes.stepAcc) begin
      phaseQ <= phaseSum[RATE_W-1:0];
      tickQ  <= phaseSum[RATE_W];
    end else begin
      tickQ  <= 1'b0;
    end
  end

  // R2: a clear cycle is followed by a quiet output
  p_clear_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clr |=> !tickQ);

  // R4: periods of 0 or 1 tick on every step
  p_fast_div_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepDiv && rateVal <= ONE) |=> tickQ);

  // R3: counter stays below the period while stepping
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepDiv && rateVal > ONE) |-> (cntQ < rateVal));

  // R6: small increments cannot carry on two steps in a row
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tickQ && strobes.stepAcc && rateVal < HALF) |=> !tickQ);

  // R9: zero increment never ticks
  p_zero_rate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepAcc && rateVal == '0) |=> !tickQ);

endmodule

// File: rtl/dual_rate_tick.sv
module dual_rate_tick
  import dual_rate_tick_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              accSel,
  input  logic [RATE_W-1:0] rateVal,
  output logic              tickOut
);

  tickStrobes_t strobes;

  dual_rate_tick_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .accSel  (accSel),
    .rateVal (rateVal),
    .strobes (strobes)
  );

  dual_rate_tick_dp #(.RATE_W(RATE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rateVal (rateVal),
    .tickQ   (tickOut)
  );

  // R1: output low straight out of reset
  p_reset_low_r1: assert property (@(posedge clk)
    !rstN |=> !tickOut);

  // R2: stopped generator is quiet
  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !tickOut);

  // R7: mode flip costs one quiet clear cycle
  p_mode_flip_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && accSel != $past(accSel)) |=> !tickOut);

  // R8: rate change costs one quiet clear cycle
  p_rate_change_r8: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && rateVal != $past(rateVal)) |=> !tickOut);

endmodule

// File: tb/dual_rate_tick_tb.sv
`timescale 1ns/1ps
module dual_rate_tick_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        runEn;
  logic        accSel;
  logic [15:0] rateVal;
  logic        tickOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  int tickCnt, firstAt, maxRun;

  always #2 clk = ~clk;

  dual_rate_tick u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .accSel(accSel),
    .rateVal(rateVal), .tickOut(tickOut)
  );

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic longint expDivCount(longint n, longint m);
    return (n <= 1) ? m : m / n;
  endfunction
  function automatic longint expDivFirst(longint n);
    return (n <= 1) ? 1 : n;
  endfunction
  function automatic longint expAccCount(longint v, longint m);
    return (m * v) >> 16;
  endfunction
  function automatic longint expAccFirst(longint v);
    return (65536 + v - 1) / v;
  endfunction

  // Stop, load a new configuration, then start on the next clock.
  task automatic startCfg(input logic acc, input logic [15:0] val);
    @(negedge clk); runEn = 1'b0;
    repeat (2) @(negedge clk);
    accSel = acc; rateVal = val;
    repeat (2) @(negedge clk);
    runEn = 1'b1;
  endtask

  // Observe m clock edges; index 1 is the first edge after this call.
  task automatic measure(input int m);
    int run;
    tickCnt = 0; firstAt = 0; maxRun = 0; run = 0;
    for (int i = 1; i <= m; i++) begin
      @(posedge clk); #1;
      if (tickOut) begin
        tickCnt++;
        if (firstAt == 0) firstAt = i;
        run++;
        if (run > maxRun) maxRun = run;
      end else begin
        run = 0;
      end
    end
  endtask

  task automatic runDiv(input logic [15:0] n, input int m);
    startCfg(1'b0, n);
    measure(m);
    check(tickCnt == expDivCount(n, m), (n <= 1) ? "R4 count" : "R3 count", tickCnt, expDivCount(n, m));
    check(firstAt == expDivFirst(n), (n <= 1) ? "R4 first" : "R3 first", firstAt, expDivFirst(n));
    if (n >= 2) check(maxRun <= 1, "R6 pulse width div", maxRun, 1);
  endtask

  task automatic runAcc(input logic [15:0] v, input int m);
    startCfg(1'b1, v);
    measure(m);
    check(tickCnt == expAccCount(v, m), "R5 count", tickCnt, expAccCount(v, m));
    if (expAccFirst(v) <= m)
      check(firstAt == expAccFirst(v), "R5 first", firstAt, expAccFirst(v));
    if (v < 16'h8000) check(maxRun <= 1, "R6 pulse width acc", maxRun, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; runEn = 1'b1; accSel = 1'b0; rateVal = 16'd1;
    // R1: reset holds output low even with a config that would tick every clock
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check(tickOut == 1'b0, "R1 in reset", tickOut, 0);
    end
    @(negedge clk); rstN = 1'b1; runEn = 1'b0;
    @(posedge clk); #1;
    check(tickOut == 1'b0, "R1 after reset", tickOut, 0);

    // Directed counter mode
    runDiv(16'd4, 40);
    runDiv(16'd2, 20);
    runDiv(16'd1, 15);
    runDiv(16'd0, 15);
    runDiv(16'd1000, 5000);

    // Directed accumulator mode
    runAcc(16'h1000, 200);
    runAcc(16'hFFFF, 100);
    runAcc(16'h8000, 64);
    runAcc(16'd1, 65600);

    // R9: zero increment
    startCfg(1'b1, 16'd0);
    measure(300);
    check(tickCnt == 0, "R9 zero increment", tickCnt, 0);

    // R2: stop part way, output quiet, restart from zero
    startCfg(1'b0, 16'd3);
    measure(2);
    @(negedge clk); runEn = 1'b0;
    measure(5);
    check(tickCnt == 0, "R2 quiet while stopped", tickCnt, 0);
    @(negedge clk); runEn = 1'b1;
    measure(9);
    check(firstAt == 3, "R2 restart from zero", firstAt, 3);
    check(tickCnt == 3, "R2 count after resume", tickCnt, 3);

    // R7: acc 0xC000 one step, flip out to counter mode and back
    startCfg(1'b1, 16'hC000);
    measure(1);
    check(tickCnt == 0, "R7 setup no carry", tickCnt, 0);
    @(negedge clk); accSel = 1'b0;
    @(negedge clk); accSel = 1'b1;
    measure(6);
    check(firstAt == 3, "R7 first after mode flip", firstAt, 3);
    check(tickCnt == 3, "R7 count after mode flip", tickCnt, 3);

    // R8: counter at 3 of 5, change period to 6
    startCfg(1'b0, 16'd5);
    measure(3);
    @(negedge clk); rateVal = 16'd6;
    measure(13);
    check(firstAt == 7, "R8 first after rate change", firstAt, 7);
    check(tickCnt == 2, "R8 count after rate change", tickCnt, 2);

    // Random rounds over both modes
    for (int r = 0; r < 10; r++) begin
      if ($urandom_range(1, 0) == 0)
        runDiv(16'($urandom_range(63, 0)), 1500);
      else
        runAcc(16'($urandom_range(16'hFFFF, 16'h0100)), 1500);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule